// File: doc/BRIEF.md
# DRAM Refresh Cycle Controller

This block schedules periodic refresh cycles for dynamic memory hanging off a small 8-bit processor bus. A free-running timer counts processor clocks and raises a refresh request at a programmable interval. The request is held pending and turned into a refresh bus cycle at the next machine-cycle boundary that the processor reports. During that cycle the block drives a refresh strobe and an 8-bit row address that advances once per completed refresh.

A 4-bit control word sets the timing. It holds an enable bit, a wait bit that picks a 2-clock or a 3-clock refresh cycle, and a 2-bit interval select. While another master owns the bus, requests are dropped but the timer keeps counting. In that case the next refresh comes at the timer's own phase. While the processor sits in a halt or sleep state, the latest request is held in a single latch. That request is issued at the first machine-cycle end after the state is left.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the strobe and the acknowledge are low and the address is 0. The configuration is enabled, with the wait bit set and interval select 00.
- R2: A write with `cfg_we_i` high loads the control word. Bit 3 is enable, bit 2 is the wait bit and bits 1:0 are the interval select.
- R3: While enable is 0, no refresh strobe is raised, any pending request is discarded and the address holds.
- R4: A refresh cycle keeps `rfsh_o` high for 3 consecutive clocks when the wait bit is 1, and for 2 clocks when it is 0.
- R5: With `mcycle_end_i` held high, successive rising edges of `rfsh_o` are 10, 20, 40 or 80 clocks apart for interval select 00, 01, 10 or 11.
- R6: A refresh starts only on a clock where `mcycle_end_i` is high. `rfsh_o` rises in the cycle after that boundary is sampled with a request pending.
- R7: While `bus_released_i` is high, no refresh starts and requests are discarded. The timer keeps running, so the first refresh after reacquisition falls on the same interval grid as before.
- R8: A request raised while `lowpower_i` is high is latched once, however many intervals pass. It is issued at the first clock with `mcycle_end_i` high after `lowpower_i` falls.
- R9: `rfsh_addr_o` increments by exactly 1 at the end of each completed refresh cycle and wraps from 255 to 0.
- R10: `rfsh_ack_o` is a one-clock pulse in the last clock of each refresh cycle. The strobe is low in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 4 | Control word: enable, wait, interval select |
| mcycle_end_i | input | 1 | Machine-cycle boundary from the processor |
| bus_released_i | input | 1 | Bus is granted to another master |
| lowpower_i | input | 1 | Processor is halted or sleeping |
| rfsh_o | output | 1 | Refresh strobe, high for the whole refresh cycle |
| rfsh_ack_o | output | 1 | Pulse on the last clock of a refresh cycle |
| rfsh_addr_o | output | 8 | Refresh row address |

## Verification
The hardest case is the latched request across a low-power period. To check it, the processor is held in low power for several whole intervals. Then low power is dropped while the machine-cycle boundary is kept low for a few clocks, so any early insertion would show up. The boundary is then raised, and the bench expects the strobe one clock later and the address exactly one above its pre-sleep value. Timer continuity across a bus release is checked a different way: the bench compares the phase, modulo the interval, of the refreshes before and after the release.

// File: rtl/refresh_pkg.sv
`timescale 1ns/1ps
package refresh_pkg;
  typedef struct packed {
    logic       en;
    logic       wt;
    logic [1:0] sel;
  } rfsh_cfg_t;

  localparam rfsh_cfg_t CFG_RESET = '{en: 1'b1, wt: 1'b1, sel: 2'b00};
endpackage

// File: rtl/refresh_timer.sv
`timescale 1ns/1ps
module refresh_timer #(
  parameter int BASE  = 10,
  parameter int CNT_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_m1;

  always_comb begin
    limit_m1 = (CNT_W'(BASE) << sel_i) - CNT_W'(1);
    tick_o   = (cnt_q >= limit_m1);
  end

  // free-running, never held by bus or power state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  p_tick_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $stable(sel_i)) |=> !tick_o);
endmodule

// File: rtl/refresh_sequencer.sv
`timescale 1ns/1ps
module refresh_sequencer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wt_i,
  input  logic tick_i,
  input  logic mcycle_end_i,
  input  logic bus_released_i,
  input  logic lowpower_i,
  output logic busy_o,
  output logic ack_o
);
  logic       pend_q;
  logic       busy_q;
  logic [1:0] len_q;
  logic       start;

  assign start  = pend_q && !busy_q && en_i && mcycle_end_i && !lowpower_i && !bus_released_i;
  assign ack_o  = busy_q && (len_q == 2'd0);
  assign busy_o = busy_q;

  // single latch: newer requests overwrite, never accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (!en_i || bus_released_i) pend_q <= 1'b0;
    else if (tick_i)                  pend_q <= 1'b1;
    else if (ack_o)                   pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      len_q  <= wt_i ? 2'd2 : 2'd1;
    end else if (busy_q) begin
      if (len_q == 2'd0) busy_q <= 1'b0;
      else               len_q  <= len_q - 2'd1;
    end
  end

  p_no_start_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && bus_released_i) |=> !busy_q);
  p_disabled_drops_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q);
  p_start_on_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(mcycle_end_i) && !$past(lowpower_i));
  p_ack_ends_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !busy_q);
endmodule

// File: rtl/refresh_addr_counter.sv
`timescale 1ns/1ps
module refresh_addr_counter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (ack_i) addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr_o = addr_q;

  p_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> addr_q == $past(addr_q) + ADDR_W'(1));
  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(addr_q));
endmodule

// File: rtl/dram_refresh_ctrl.sv
`timescale 1ns/1ps
module dram_refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int BASE_INTERVAL = 10,
  parameter int ADDR_W        = 8,
  localparam int CNT_W        = $clog2(BASE_INTERVAL * 8 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              mcycle_end_i,
  input  logic              bus_released_i,
  input  logic              lowpower_i,
  output logic              rfsh_o,
  output logic              rfsh_ack_o,
  output logic [ADDR_W-1:0] rfsh_addr_o
);
  rfsh_cfg_t cfg_q;
  logic      tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= rfsh_cfg_t'(cfg_wdata_i);
  end

  refresh_timer #(.BASE(BASE_INTERVAL), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cfg_q.sel),
    .tick_o (tick)
  );

  refresh_sequencer u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (cfg_q.en),
    .wt_i           (cfg_q.wt),
    .tick_i         (tick),
    .mcycle_end_i   (mcycle_end_i),
    .bus_released_i (bus_released_i),
    .lowpower_i     (lowpower_i),
    .busy_o         (rfsh_o),
    .ack_o          (rfsh_ack_o)
  );

  refresh_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (rfsh_ack_o),
    .addr_o (rfsh_addr_o)
  );

  p_cfg_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q == rfsh_cfg_t'($past(cfg_wdata_i)));
endmodule

// File: tb/dram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [3:0] cfg_wdata_i = 4'h0;
  logic       mcycle_end_i = 1'b1;
  logic       bus_released_i = 1'b0;
  logic       lowpower_i = 1'b0;
  logic       rfsh_o;
  logic       rfsh_ack_o;
  logic [7:0] rfsh_addr_o;

  int n_chk = 0, n_err = 0;
  int cyc = 0, rise_cnt = 0, fall_cnt = 0, last_rise = 0, last_period = 0;
  int hi = 0, last_width = 0, wd = 0;
  logic prev_r = 1'b0, prev_a = 1'b0, done = 1'b0;

  always #4 clk_i = ~clk_i;

  dram_refresh_ctrl uut (.*);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor, sampled at the falling edge
  always @(negedge clk_i) if (rst_ni) begin
    cyc++;
    if (rfsh_o && !prev_r) begin
      rise_cnt++;
      last_period = cyc - last_rise;
      last_rise = cyc;
    end
    if (rfsh_o) hi++;
    if (!rfsh_o && prev_r) begin
      last_width = hi;
      hi = 0;
      fall_cnt++;
    end
    if (rfsh_ack_o) check(rfsh_o, "R10 ack inside strobe", rfsh_ack_o, 1);
    if (prev_a) check(!rfsh_o && !rfsh_ack_o, "R10 strobe low after ack", rfsh_o, 0);
    prev_r = rfsh_o;
    prev_a = rfsh_ack_o;
  end

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_rise();
    int c = rise_cnt;
    while (rise_cnt == c) step();
  endtask

  task automatic wait_fall();
    int c = fall_cnt;
    while (fall_cnt == c) step();
  endtask

  task automatic write_cfg(input logic en, input logic wt, input logic [1:0] sel);
    cfg_wdata_i = {en, wt, sel};
    cfg_we_i = 1'b1;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check(rfsh_o == 1'b0, "R1 strobe after reset", rfsh_o, 0);
    check(rfsh_ack_o == 1'b0, "R1 ack after reset", rfsh_ack_o, 0);
    check(rfsh_addr_o == 8'd0, "R1 addr after reset", rfsh_addr_o, 0);
  endtask

  task automatic t_defaults();
    wait_rise(); wait_rise();
    check(last_period == 10, "R1 default interval", last_period, 10);
    wait_fall();
    check(last_width == 3, "R1 R4 default width", last_width, 3);
  endtask

  task automatic t_width();
    write_cfg(1'b1, 1'b0, 2'b00);
    wait_rise(); wait_fall();
    check(last_width == 2, "R4 R2 no-wait width", last_width, 2);
    write_cfg(1'b1, 1'b1, 2'b00);
    wait_rise(); wait_fall();
    check(last_width == 3, "R4 wait width", last_width, 3);
  endtask

  task automatic t_interval(input logic [1:0] sel, input int exp);
    write_cfg(1'b1, 1'b1, sel);
    wait_rise(); wait_rise(); wait_rise();
    check(last_period == exp, "R5 interval", last_period, exp);
  endtask

  task automatic t_disable();
    int c;
    logic [7:0] a;
    wait_rise(); steps(5);
    write_cfg(1'b0, 1'b1, 2'b00);
    c = rise_cnt; a = rfsh_addr_o;
    steps(200);
    check(rise_cnt == c, "R3 no strobe when disabled", rise_cnt - c, 0);
    check(rfsh_addr_o == a, "R3 addr holds when disabled", rfsh_addr_o, a);
    write_cfg(1'b1, 1'b1, 2'b00);
    wait_rise();
    check(1'b1, "R3 resumes", 1, 1);
  endtask

  task automatic t_bus_release();
    int r0, c;
    wait_rise(); r0 = last_rise;
    steps(5);
    bus_released_i = 1'b1;
    c = rise_cnt;
    steps(93);
    check(rise_cnt == c, "R7 no strobe while released", rise_cnt - c, 0);
    bus_released_i = 1'b0;
    wait_rise();
    check(((last_rise - r0) % 10) == 0, "R7 timer phase kept", (last_rise - r0) % 10, 0);
  endtask

  task automatic t_lowpower();
    int c;
    logic [7:0] a;
    wait_rise(); steps(5);
    lowpower_i = 1'b1;
    c = rise_cnt; a = rfsh_addr_o;
    steps(35);
    check(rise_cnt == c, "R8 no strobe in low power", rise_cnt - c, 0);
    lowpower_i = 1'b0;
    mcycle_end_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(rfsh_o == 1'b0, "R6 waits for boundary", rfsh_o, 0);
    end
    mcycle_end_i = 1'b1;
    step();
    check(rfsh_o == 1'b1, "R8 R6 latched request inserted", rfsh_o, 1);
    wait_fall();
    check(rfsh_addr_o == a + 8'd1, "R8 R9 single refresh for missed requests", rfsh_addr_o, a + 8'd1);
  endtask

  task automatic t_wrap();
    int guard = 0;
    while (rfsh_addr_o != 8'd255 && guard < 5000) begin step(); guard++; end
    check(rfsh_addr_o == 8'd255, "R9 reached 255", rfsh_addr_o, 255);
    wait_fall();
    check(rfsh_addr_o == 8'd0, "R9 wrap to 0", rfsh_addr_o, 0);
    wait_fall();
    check(rfsh_addr_o == 8'd1, "R9 step after wrap", rfsh_addr_o, 1);
  endtask

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    steps(3);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_defaults();
    t_width();
    t_interval(2'b01, 20);
    t_interval(2'b10, 40);
    t_interval(2'b11, 80);
    t_interval(2'b00, 10);
    t_disable();
    t_bus_release();
    t_lowpower();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule